// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block watches the head of each received frame on a byte-wide stream and decides whether a group (multicast) destination address should be accepted. A frame begins with a byte flagged by start-of-frame; the first six valid bytes form the destination address. While those bytes arrive, the block runs a CRC-32 over them. When the sixth byte has been taken, it turns the CRC into an 8-bit hash index and looks it up in a 256-entry bit table. The table is laid out as eight 32-bit words.

Software owns the table through a small write port. A write can replace a word, OR bits into it, or clear bits in it, so a single entry can be changed without a read-modify-write. Every word can be read back. A promiscuous input forces acceptance of every frame. An address whose group bit is clear never consults the table.

Top module: `mhf_filter`

## Requirements
- R1: After reset all eight table words read back as zero, and dec_done and dec_accept are low.
- R2: A valid byte with rx_sof high is address byte 0, and the next five valid bytes (rx_valid high) are bytes 1 to 5. Cycles with rx_valid low are skipped. A new rx_sof at any point restarts capture at byte 0.
- R3: The hash CRC uses polynomial 0x04C11DB7 with a preset of all ones and no final inversion. It consumes the address bytes in arrival order and each byte least significant bit first. The hash index is bits 31..24 of the bit-reversed CRC, so index bit 7 is CRC bit 0.
- R4: Index bits 7..5 select the table word and bits 4..0 give a position b, where entry b is word bit 31-b. Entry 0 is bit 31 of word 0 and entry 255 is bit 0 of word 7. A group address is accepted exactly when its entry is 1.
- R5: dec_done is high for exactly the one cycle after the clock edge that takes address byte 5, and it carries that frame's decision on dec_accept. dec_accept is low whenever dec_done is low.
- R6: When bit 0 of address byte 0 is 0, the frame is rejected whatever the table holds, unless rx_promisc is high.
- R7: When rx_promisc is high at the edge that takes address byte 5, the frame is accepted.
- R8: When tbl_we is high, tbl_op selects the update to the word at tbl_addr: 0 writes tbl_wdata, 1 ORs tbl_wdata in, 2 clears the bits set in tbl_wdata, and 3 leaves the word unchanged. Other words never change. tbl_rdata shows the word at tbl_addr without delay.
- R9: Valid bytes before the first rx_sof, and bytes after address byte 5 until the next rx_sof, produce no dec_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_valid | input | 1 | Byte on rx_data is valid this cycle |
| rx_data | input | 8 | Received byte |
| rx_promisc | input | 1 | Accept every frame |
| tbl_we | input | 1 | Table update strobe |
| tbl_op | input | 2 | Update kind: 0 write, 1 set bits, 2 clear bits, 3 none |
| tbl_addr | input | 3 | Table word for update and readback |
| tbl_wdata | input | 32 | Update data or bit mask |
| tbl_rdata | output | 32 | Word at tbl_addr |
| dec_done | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted, valid with dec_done |

## Verification
The assertions check the following on every cycle:
- dec_done follows the last-address-byte event by exactly one cycle, and never appears without that event.
- dec_accept never rises without dec_done.
- Group-bit-clear addresses are rejected and promiscuous frames are accepted.
- A table word changes only under a write strobe, set and clear leave the masked bits in the right state, and unaddressed words hold.

Only the bench scenarios can show that the hash itself is right. They compare decisions against an independent CRC and index model, with addresses found by search that land on entries 0 and 255 at the table's two ends. The scenarios also cover a capture restarted by an early start-of-frame, idle gaps inside the address, and readback after each kind of update.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned CRC_W       = 32;
  localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;

  typedef enum logic [1:0] {
    TBL_WRITE = 2'd0,
    TBL_SET   = 2'd1,
    TBL_CLEAR = 2'd2,
    TBL_NONE  = 2'd3
  } tbl_op_e;

  // One byte of CRC, bits consumed least significant first.
  function automatic logic [CRC_W-1:0] crc_step_byte(
    input logic [CRC_W-1:0]  crc_in,
    input logic [BYTE_W-1:0] data,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_in;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[CRC_W-1] ^ data[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_addr_capture.sv
module mhf_addr_capture #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_sof,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              byte_take,
  output logic              byte_first,
  output logic              byte_last,
  output logic              group_now
);
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             group_q;

  assign byte_first = rx_valid && rx_sof;
  assign byte_take  = byte_first || (rx_valid && active_q);
  assign group_now  = byte_first ? rx_data[0] : group_q;

  always_comb begin
    if (byte_first)
      byte_last = (ADDR_BYTES == 1);
    else
      byte_last = byte_take && (cnt_q == CNT_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      group_q  <= 1'b0;
    end else if (byte_take) begin
      if (byte_first) begin
        cnt_q   <= CNT_W'(1);
        group_q <= rx_data[0];
      end else begin
        cnt_q   <= cnt_q + CNT_W'(1);
      end
      active_q <= !byte_last;
    end
  end
endmodule

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine
  import mhf_pkg::*;
#(
  parameter logic [31:0] POLY = CRC_POLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_take,
  input  logic              byte_first,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_next
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;

  assign crc_base = byte_first ? {CRC_W{1'b1}} : crc_q;
  assign crc_next = crc_step_byte(crc_base, data, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_q <= {CRC_W{1'b1}};
    else if (byte_take) crc_q <= crc_next;
  end
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
  import mhf_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tbl_we,
  input  logic [1:0]                  tbl_op,
  input  logic [$clog2(NUM_WORDS)-1:0] tbl_addr,
  input  logic [WORD_W-1:0]           tbl_wdata,
  output logic [WORD_W-1:0]           tbl_rdata,
  output logic [NUM_WORDS*WORD_W-1:0] tbl_flat
);
  localparam int unsigned SEL_W = $clog2(NUM_WORDS);

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit;
    assign hit = tbl_we && (tbl_addr == SEL_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (hit) begin
        case (tbl_op)
          TBL_WRITE: word_q <= tbl_wdata;
          TBL_SET:   word_q <= word_q | tbl_wdata;
          TBL_CLEAR: word_q <= word_q & ~tbl_wdata;
          default:   word_q <= word_q;
        endcase
      end
    end
    assign tbl_flat[k*WORD_W +: WORD_W] = word_q;
  end

  assign tbl_rdata = tbl_flat[tbl_addr*WORD_W +: WORD_W];
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned NUM_WORDS  = 8,
  parameter int unsigned WORD_W     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_sof,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_promisc,
  input  logic        tbl_we,
  input  logic [1:0]  tbl_op,
  input  logic [2:0]  tbl_addr,
  input  logic [31:0] tbl_wdata,
  output logic [31:0] tbl_rdata,
  output logic        dec_done,
  output logic        dec_accept
);
  localparam int unsigned SEL_W = $clog2(NUM_WORDS);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam int unsigned IDX_W = SEL_W + BIT_W;

  logic                        addr_take;
  logic                        addr_first;
  logic                        addr_last;
  logic                        addr_group;
  logic [CRC_W-1:0]            crc_next;
  logic [NUM_WORDS*WORD_W-1:0] tbl_flat;
  logic [IDX_W-1:0]            hash_idx;
  logic [SEL_W-1:0]            hash_sel;
  logic [BIT_W-1:0]            hash_pos;
  logic [WORD_W-1:0]           sel_word;
  logic                        hash_hit;
  logic                        accept_d;
  logic                        done_q;
  logic                        accept_q;

  mhf_addr_capture #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_sof     (rx_sof),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .byte_take  (addr_take),
    .byte_first (addr_first),
    .byte_last  (addr_last),
    .group_now  (addr_group)
  );

  mhf_crc_engine #(.POLY(CRC_POLY)) u_crc (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_take  (addr_take),
    .byte_first (addr_first),
    .data       (rx_data),
    .crc_next   (crc_next)
  );

  mhf_hash_table #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tbl_we     (tbl_we),
    .tbl_op     (tbl_op),
    .tbl_addr   (tbl_addr),
    .tbl_wdata  (tbl_wdata),
    .tbl_rdata  (tbl_rdata),
    .tbl_flat   (tbl_flat)
  );

  // Top index bits of the bit-reversed CRC are the low CRC bits reversed.
  always_comb begin
    for (int i = 0; i < IDX_W; i++) hash_idx[IDX_W-1-i] = crc_next[i];
  end

  assign hash_sel = hash_idx[IDX_W-1 -: SEL_W];
  assign hash_pos = hash_idx[BIT_W-1:0];
  assign sel_word = tbl_flat[hash_sel*WORD_W +: WORD_W];
  assign hash_hit = sel_word[BIT_W'(WORD_W-1) - hash_pos];
  assign accept_d = rx_promisc || (addr_group && hash_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      done_q   <= addr_last;
      accept_q <= addr_last && accept_d;
    end
  end

  assign dec_done   = done_q;
  assign dec_accept = accept_q;
endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned WORD_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rx_promisc,
  input logic                        addr_last,
  input logic                        addr_group,
  input logic                        dec_done,
  input logic                        dec_accept,
  input logic                        tbl_we,
  input logic [1:0]                  tbl_op,
  input logic [$clog2(NUM_WORDS)-1:0] tbl_addr,
  input logic [WORD_W-1:0]           tbl_wdata,
  input logic [NUM_WORDS*WORD_W-1:0] tbl_flat
);
  logic                        p_we;
  logic [1:0]                  p_op;
  logic [$clog2(NUM_WORDS)-1:0] p_addr;
  logic [WORD_W-1:0]           p_data;
  logic [NUM_WORDS*WORD_W-1:0] p_flat;
  logic [NUM_WORDS*WORD_W-1:0] p_mask;
  logic [WORD_W-1:0]           cur_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_we <= 1'b0; p_op <= '0; p_addr <= '0; p_data <= '0; p_flat <= '0;
    end else begin
      p_we <= tbl_we; p_op <= tbl_op; p_addr <= tbl_addr;
      p_data <= tbl_wdata; p_flat <= tbl_flat;
    end
  end

  always_comb begin
    p_mask = '0;
    p_mask[p_addr*WORD_W +: WORD_W] = '1;
  end
  assign cur_word = tbl_flat[p_addr*WORD_W +: WORD_W];

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    addr_last |=> dec_done); // R5
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_last |=> !dec_done); // R9
  AST_ACCEPT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_done); // R5
  AST_UNICAST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_last && !addr_group && !rx_promisc) |=> !dec_accept); // R6
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_last && rx_promisc) |=> dec_accept); // R7
  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_we |=> $stable(tbl_flat)); // R8
  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (p_we && p_op == 2'd1) |-> ((cur_word & p_data) == p_data)); // R8
  AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (p_we && p_op == 2'd2) |-> ((cur_word & p_data) == '0)); // R8
  AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    p_we |-> (((tbl_flat ^ p_flat) & ~p_mask) == '0)); // R8
endmodule

bind mhf_filter mhf_filter_chk #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_promisc (rx_promisc),
  .addr_last  (addr_last),
  .addr_group (addr_group),
  .dec_done   (dec_done),
  .dec_accept (dec_accept),
  .tbl_we     (tbl_we),
  .tbl_op     (tbl_op),
  .tbl_addr   (tbl_addr),
  .tbl_wdata  (tbl_wdata),
  .tbl_flat   (tbl_flat)
);

// File: tb/mhf_filter_tb.sv
module mhf_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_promisc = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_op = '0;
  logic [2:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic [31:0] tbl_rdata;
  logic        dec_done, dec_accept;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;
  logic [31:0] model [8];

  mhf_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_promisc(rx_promisc), .tbl_we(tbl_we),
    .tbl_op(tbl_op), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .tbl_rdata(tbl_rdata), .dec_done(dec_done), .dec_accept(dec_accept)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench CRC model: shift-and-mask form.
  function automatic logic [31:0] ref_crc(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++)
      c = (c << 1) ^ ({32{c[31] ^ da[n]}} & 32'h04C1_1DB7);
    return c;
  endfunction

  function automatic logic [7:0] ref_index(input logic [47:0] da);
    logic [31:0] c = ref_crc(da);
    logic [31:0] r;
    for (int n = 0; n < 32; n++) r[31-n] = c[n];
    return r[31:24];
  endfunction

  function automatic bit ref_accept(input logic [47:0] da, input bit promisc);
    logic [7:0] ix = ref_index(da);
    if (promisc) return 1'b1;
    if (!da[0]) return 1'b0;
    return model[ix >> 5][31 - (ix & 8'd31)];
  endfunction

  task automatic tbl_cmd(input logic [1:0] op, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_op = op; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
    case (op)
      2'd0: model[a] = d;
      2'd1: model[a] = model[a] | d;
      2'd2: model[a] = model[a] & ~d;
      default: ;
    endcase
  endtask

  task automatic readback_all(input string req);
    for (int k = 0; k < 8; k++) begin
      tbl_addr = 3'(k);
      #1;
      chk(req, tbl_rdata, model[k]);
    end
  endtask

  task automatic put_byte(input bit sof, input logic [7:0] d, inout bit early);
    @(negedge clk);
    if (dec_done) early = 1;
    rx_valid = 1'b1; rx_sof = sof; rx_data = d;
  endtask

  task automatic idle_cycle(inout bit early);
    @(negedge clk);
    if (dec_done) early = 1;
    rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  // Sends the address, checks done/decision one cycle after byte 5 and the drop after.
  task automatic send_frame(input logic [47:0] da, input bit gaps, input bit promisc,
                            input string req);
    bit early = 0;
    bit expa;
    rx_promisc = promisc;
    for (int i = 0; i < 6; i++) begin
      if (gaps && (i == 2 || i == 4)) idle_cycle(early);
      put_byte(i == 0, da[8*i +: 8], early);
    end
    expa = ref_accept(da, promisc);
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    chk({req, " R5 done"}, {31'd0, dec_done}, 32'd1);
    chk({req, " decision"}, {31'd0, dec_accept}, {31'd0, expa});
    chk("R9 no early done", {31'd0, early}, 32'd0);
    @(negedge clk);
    chk("R5 single pulse", {31'd0, dec_done, dec_accept}, 32'd0);
    rx_promisc = 1'b0;
  endtask

  function automatic logic [47:0] find_addr(input logic [7:0] target);
    logic [47:0] da;
    for (int t = 0; t < 50000; t++) begin
      da = {$urandom, $urandom};
      da[0] = 1'b1;
      if (ref_index(da) == target) return da;
    end
    return 48'h1;
  endfunction

  initial begin
    logic [47:0] da;
    bit early;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int k = 0; k < 8; k++) model[k] = '0;

    repeat (3) @(negedge clk);
    chk("R1 done in reset", {30'd0, dec_done, dec_accept}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", {30'd0, dec_done, dec_accept}, 32'd0);
    readback_all("R1 table zero");

    // R9: valid bytes before any start-of-frame
    early = 0;
    for (int i = 0; i < 8; i++) put_byte(1'b0, 8'($urandom), early);
    idle_cycle(early); idle_cycle(early);
    chk("R9 bytes before sof", {31'd0, early}, 32'd0);

    // R8 table operations
    tbl_cmd(2'd0, 3'd3, 32'hA5A5_0F0F);
    tbl_cmd(2'd1, 3'd3, 32'h0000_F0F0);
    tbl_cmd(2'd2, 3'd3, 32'hA000_000F);
    tbl_cmd(2'd3, 3'd3, 32'hFFFF_FFFF);
    tbl_cmd(2'd1, 3'd6, 32'h0000_0001);
    readback_all("R8 table ops");
    chk("R8 word3 value", model[3], 32'h05A5_FFF0);

    // R4 ends of the table: entry 0 and entry 255
    for (int k = 0; k < 8; k++) tbl_cmd(2'd0, 3'(k), 32'h0);
    da = find_addr(8'd0);
    send_frame(da, 0, 0, "R4 entry0 clear");
    tbl_cmd(2'd0, 3'd0, 32'h8000_0000);
    send_frame(da, 0, 0, "R4 entry0 set");
    da = find_addr(8'd255);
    send_frame(da, 1, 0, "R4 entry255 clear");
    tbl_cmd(2'd1, 3'd7, 32'h0000_0001);
    send_frame(da, 1, 0, "R4 entry255 set");

    // R6 / R7 with a full table
    for (int k = 0; k < 8; k++) tbl_cmd(2'd0, 3'(k), 32'hFFFF_FFFF);
    da = {$urandom, $urandom}; da[0] = 1'b0;
    send_frame(da, 0, 0, "R6 unicast reject");
    send_frame(da, 0, 1, "R7 promisc unicast");
    for (int k = 0; k < 8; k++) tbl_cmd(2'd0, 3'(k), 32'h0);
    da[0] = 1'b1;
    send_frame(da, 0, 1, "R7 promisc group");

    // R2 restart: partial frame then a fresh sof
    tbl_cmd(2'd0, 3'(ref_index(da) >> 5), 32'h8000_0000 >> (ref_index(da) & 8'd31));
    early = 0;
    for (int i = 0; i < 3; i++) put_byte(i == 0, 8'($urandom) | 8'h01, early);
    send_frame(da, 0, 0, "R2 restart");

    // R9 trailing bytes after the address
    early = 0;
    for (int i = 0; i < 10; i++) put_byte(1'b0, 8'($urandom), early);
    idle_cycle(early); idle_cycle(early);
    chk("R9 trailing bytes", {31'd0, early}, 32'd0);

    // R3 random tables and group addresses
    for (int n = 0; n < 60; n++) begin
      if (n % 10 == 0)
        for (int k = 0; k < 8; k++) tbl_cmd(2'($urandom_range(0, 3)), 3'(k), $urandom);
      da = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0) da[0] = 1'b1;
      send_frame(da, n[0], ($urandom_range(0, 9) == 0), "R3 hash decision");
    end
    readback_all("R8 final readback");

    summary();
  end
endmodule